// File: doc/BRIEF.md
# Compare-and-Branch Fusion Stage

This stage sits between an instruction decoder and a micro-op queue. Every instruction enters as a single micro-op through a ready/valid port. When a flag-setting arithmetic instruction is followed directly by a conditional branch that tests a fusible condition, the stage merges the two into one micro-op. That merged micro-op performs the arithmetic, writes the flags and the destination register, and then redirects to the branch target when the condition holds. All other instructions pass through unchanged, and program order is always kept.

A policy input decides which arithmetic instructions may lead a pair. In the narrow setting only compare and test qualify. In the wide setting add and subtract also qualify, whether their operand is a register or an immediate. Under the wide policy, a loop counter decrement followed by a jump-if-not-zero therefore becomes a single subtract-and-branch micro-op.

A possible pair leader is held in a one-entry slot. It waits at most one cycle for its successor. If the successor does not arrive in time, or arrives and cannot fuse, the leader is sent out alone. A flush discards whatever the slot holds.

Top module: `fuse_unit`

## Requirements
- R1: After reset, and before any input is offered, out_valid_o is low and in_ready_o is high.
- R2: With wide_i low, a compare (kind 1) or test (kind 2) followed immediately by a branch (kind 5) with a fusible condition produces exactly one output. That output has out_fused_o high, carries the kind, destination and operand of the first instruction, and carries the condition and target of the branch.
- R3: With wide_i low, an add (kind 3) or subtract (kind 4) followed by a branch produces two outputs with out_fused_o low: the arithmetic instruction first, then the branch.
- R4: With wide_i high, an add or subtract followed immediately by a branch with a fusible condition fuses exactly as in R2. This includes a subtract followed by a not-zero branch.
- R5: Only condition codes 0 (zero), 1 (not zero), 2 (carry) and 3 (not carry) can fuse. A branch with any code from 4 to 7 is emitted separately after its leader.
- R6: Only the next instruction can join a leader. If that instruction is not a branch, the leader goes out alone first and the next instruction follows it. A non-arithmetic instruction (kind 0) followed by a branch never fuses.
- R7: Suppose a leader is accepted into the empty stage and no valid input is offered in the following cycle. Then out_valid_o is low for that one cycle, and in the next cycle the leader is presented alone.
- R8: A non-leader instruction accepted into the empty stage is presented on the output in the very next cycle.
- R9: While flush_i is high, in_ready_o and out_valid_o are low. A held leader is discarded, and a later branch is emitted unfused.
- R10: An unfused output has out_fused_o low and carries every field of that one instruction.
- R11: While out_ready_i is low, a presented output stays valid, in_ready_o stays low and nothing is lost. A branch waiting at the input still fuses once out_ready_i rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | Fusion policy: 0 allows compare/test leaders only, 1 also allows add/subtract |
| flush_i | input | 1 | Discards the held instruction |
| in_valid_i | input | 1 | Input micro-op valid |
| in_ready_o | output | 1 | Stage can accept an input |
| in_kind_i | input | 3 | 0 other, 1 compare, 2 test, 3 add, 4 subtract, 5 branch |
| in_cond_i | input | 3 | Branch condition code |
| in_dst_i | input | REG_W | Destination register |
| in_opnd_i | input | OPND_W | Source operand or immediate |
| in_tgt_i | input | ADDR_W | Branch target |
| out_valid_o | output | 1 | Output micro-op valid |
| out_ready_i | input | 1 | Queue accepts the output |
| out_fused_o | output | 1 | Output is a fused arithmetic-and-branch micro-op |
| out_kind_o | output | 3 | Kind of the (leading) instruction |
| out_cond_o | output | 3 | Branch condition |
| out_dst_o | output | REG_W | Destination register |
| out_opnd_o | output | OPND_W | Source operand or immediate |
| out_tgt_o | output | ADDR_W | Branch target |

## Verification
The bench runs a table of instruction pairs, with the leader kind, the successor kind, the condition code and the policy all varied. A stage that applied the wrong policy would fuse add and subtract when it should not, or miss them when it should. A stage that decoded condition codes loosely would fuse codes 4 to 7. A stage that checked only the leader would merge a compare with a non-branch successor. Directed tests cover the remaining corners. They check the one-cycle wait of a lone leader, since a stage that stalls forever or skips the wait would show a wrong valid pattern. They check a flush while a leader is held, since a stage that still emits the leader, or fuses it with a later branch, would be caught. They check output back-pressure with a pending branch, where a lost or duplicated micro-op would change the output count.

// File: rtl/mf_pkg.sv
package mf_pkg;
  localparam int KIND_W = 3;
  localparam int COND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_OTHER = 3'd0,
    K_CMP   = 3'd1,
    K_TEST  = 3'd2,
    K_ADD   = 3'd3,
    K_SUB   = 3'd4,
    K_BR    = 3'd5
  } kind_e;

  // codes 0..3: zero, not zero, carry, not carry
  localparam logic [COND_W-1:0] FUSE_COND_MAX = 3'd3;
endpackage

// File: rtl/fuse_match.sv
module fuse_match
  import mf_pkg::*;
(
  input  logic [KIND_W-1:0] lead_kind_i,
  input  logic              wide_i,
  input  logic [KIND_W-1:0] next_kind_i,
  input  logic [COND_W-1:0] next_cond_i,
  output logic              lead_ok_o,
  output logic              tail_ok_o
);
  logic narrow_lead, wide_lead;

  always_comb begin
    narrow_lead = (lead_kind_i == K_CMP) || (lead_kind_i == K_TEST);
    wide_lead   = (lead_kind_i == K_ADD) || (lead_kind_i == K_SUB);
    lead_ok_o   = narrow_lead || (wide_i && wide_lead);
    tail_ok_o   = (next_kind_i == K_BR) && (next_cond_i <= FUSE_COND_MAX);
  end
endmodule

// File: rtl/fuse_slot.sv
module fuse_slot
  import mf_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int OPND_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [OPND_W-1:0] opnd_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic              valid_o,
  output logic              waited_o,
  output logic [KIND_W-1:0] kind_o,
  output logic [COND_W-1:0] cond_o,
  output logic [REG_W-1:0]  dst_o,
  output logic [OPND_W-1:0] opnd_o,
  output logic [ADDR_W-1:0] tgt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      waited_o <= 1'b0;
      kind_o   <= '0;
      cond_o   <= '0;
      dst_o    <= '0;
      opnd_o   <= '0;
      tgt_o    <= '0;
    end else if (load_i) begin
      valid_o  <= 1'b1;
      waited_o <= 1'b0;
      kind_o   <= kind_i;
      cond_o   <= cond_i;
      dst_o    <= dst_i;
      opnd_o   <= opnd_i;
      tgt_o    <= tgt_i;
    end else if (clear_i) begin
      valid_o  <= 1'b0;
      waited_o <= 1'b0;
    end else begin
      // any cycle spent in the slot uses up the wait allowance
      waited_o <= valid_o;
    end
  end
endmodule

// File: rtl/fuse_unit.sv
module fuse_unit
  import mf_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int OPND_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              flush_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [2:0]        in_kind_i,
  input  logic [2:0]        in_cond_i,
  input  logic [REG_W-1:0]  in_dst_i,
  input  logic [OPND_W-1:0] in_opnd_i,
  input  logic [ADDR_W-1:0] in_tgt_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_fused_o,
  output logic [2:0]        out_kind_o,
  output logic [2:0]        out_cond_o,
  output logic [REG_W-1:0]  out_dst_o,
  output logic [OPND_W-1:0] out_opnd_o,
  output logic [ADDR_W-1:0] out_tgt_o
);
  logic              slot_v, slot_waited;
  logic [KIND_W-1:0] slot_kind;
  logic [COND_W-1:0] slot_cond;
  logic [REG_W-1:0]  slot_dst;
  logic [OPND_W-1:0] slot_opnd;
  logic [ADDR_W-1:0] slot_tgt;
  logic              lead_ok, tail_ok;
  logic              pair, hold, in_fire, out_fire, load, clear;

  fuse_match u_match (
    .lead_kind_i (slot_kind),
    .wide_i      (wide_i),
    .next_kind_i (in_kind_i),
    .next_cond_i (in_cond_i),
    .lead_ok_o   (lead_ok),
    .tail_ok_o   (tail_ok)
  );

  always_comb begin
    pair        = slot_v && lead_ok && in_valid_i && tail_ok;
    hold        = slot_v && lead_ok && !in_valid_i && !slot_waited;
    out_valid_o = slot_v && !flush_i && !hold;
    in_ready_o  = !flush_i && (!slot_v || out_ready_i);
    in_fire     = in_valid_i && in_ready_o;
    out_fire    = out_valid_o && out_ready_i;
    load        = in_fire && !pair;   // a fused branch is consumed, not stored
    clear       = flush_i || out_fire;
  end

  fuse_slot #(.REG_W(REG_W), .OPND_W(OPND_W), .ADDR_W(ADDR_W)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .clear_i  (clear),
    .kind_i   (in_kind_i),
    .cond_i   (in_cond_i),
    .dst_i    (in_dst_i),
    .opnd_i   (in_opnd_i),
    .tgt_i    (in_tgt_i),
    .valid_o  (slot_v),
    .waited_o (slot_waited),
    .kind_o   (slot_kind),
    .cond_o   (slot_cond),
    .dst_o    (slot_dst),
    .opnd_o   (slot_opnd),
    .tgt_o    (slot_tgt)
  );

  always_comb begin
    out_fused_o = pair;
    out_kind_o  = slot_kind;
    out_dst_o   = slot_dst;
    out_opnd_o  = slot_opnd;
    out_cond_o  = pair ? in_cond_i : slot_cond;
    out_tgt_o   = pair ? in_tgt_i  : slot_tgt;
  end
endmodule

// File: rtl/fuse_unit_chk.sv
module fuse_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wide_i,
  input logic       flush_i,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic [2:0] in_kind_i,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic       out_fused_o,
  input logic [2:0] out_kind_o,
  input logic [2:0] out_cond_o,
  input logic       slot_v
);
  // R9
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !out_valid_o);

  // R2
  fused_consumes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_fused_o) |-> (in_valid_i && in_ready_o));

  // R5
  fused_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_fused_o) |-> (out_cond_o <= 3'd3));

  // R3
  narrow_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_fused_o && !wide_i) |-> (out_kind_o == 3'd1 || out_kind_o == 3'd2));

  // R8
  plain_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !slot_v && (in_kind_i == 3'd0 || in_kind_i == 3'd5))
      |=> (out_valid_o || flush_i));

  // R7
  hold_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_v && !out_valid_o && !flush_i) |=> (out_valid_o || flush_i));

  // R11
  stall_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !flush_i) |=> (out_valid_o || flush_i));
endmodule

bind fuse_unit fuse_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wide_i      (wide_i),
  .flush_i     (flush_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_kind_i   (in_kind_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_fused_o (out_fused_o),
  .out_kind_o  (out_kind_o),
  .out_cond_o  (out_cond_o),
  .slot_v      (slot_v)
);

// File: tb/fuse_unit_test.sv
module fuse_unit_test;
  localparam int REG_W  = 5;
  localparam int OPND_W = 16;
  localparam int ADDR_W = 32;
  localparam int NVEC   = 12;

  localparam logic [2:0] OTH = 3'd0, CMP = 3'd1, TST = 3'd2, ADD = 3'd3, SUB = 3'd4, BR = 3'd5;

  // {lead kind, next kind, next cond, wide, expect fused}
  localparam logic [10:0] VEC [NVEC] = '{
    {CMP, BR,  3'd1, 1'b0, 1'b1},
    {TST, BR,  3'd0, 1'b0, 1'b1},
    {SUB, BR,  3'd1, 1'b0, 1'b0},
    {ADD, BR,  3'd2, 1'b0, 1'b0},
    {SUB, BR,  3'd1, 1'b1, 1'b1},
    {ADD, BR,  3'd3, 1'b1, 1'b1},
    {CMP, BR,  3'd4, 1'b0, 1'b0},
    {SUB, BR,  3'd7, 1'b1, 1'b0},
    {CMP, OTH, 3'd0, 1'b0, 1'b0},
    {OTH, BR,  3'd1, 1'b1, 1'b0},
    {CMP, CMP, 3'd0, 1'b1, 1'b0},
    {TST, BR,  3'd3, 1'b1, 1'b1}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5:    return "R4";
      6, 7, 11: return "R5";
      default: return "R6";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              wide = 1'b0, flush = 1'b0;
  logic              in_valid = 1'b0, in_ready;
  logic [2:0]        in_kind = '0, in_cond = '0;
  logic [REG_W-1:0]  in_dst = '0;
  logic [OPND_W-1:0] in_opnd = '0;
  logic [ADDR_W-1:0] in_tgt = '0;
  logic              out_valid, out_ready = 1'b1, out_fused;
  logic [2:0]        out_kind, out_cond;
  logic [REG_W-1:0]  out_dst;
  logic [OPND_W-1:0] out_opnd;
  logic [ADDR_W-1:0] out_tgt;

  fuse_unit #(.REG_W(REG_W), .OPND_W(OPND_W), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .flush_i(flush),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_kind_i(in_kind),
    .in_cond_i(in_cond), .in_dst_i(in_dst), .in_opnd_i(in_opnd), .in_tgt_i(in_tgt),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_fused_o(out_fused),
    .out_kind_o(out_kind), .out_cond_o(out_cond), .out_dst_o(out_dst),
    .out_opnd_o(out_opnd), .out_tgt_o(out_tgt)
  );

  int checks = 0, errors = 0;
  int cap_n = 0;
  logic [2:0]        cap_kind  [64];
  logic [2:0]        cap_cond  [64];
  logic              cap_fused [64];
  logic [REG_W-1:0]  cap_dst   [64];
  logic [ADDR_W-1:0] cap_tgt   [64];

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && cap_n < 64) begin
      cap_kind[cap_n]  = out_kind;
      cap_cond[cap_n]  = out_cond;
      cap_fused[cap_n] = out_fused;
      cap_dst[cap_n]   = out_dst;
      cap_tgt[cap_n]   = out_tgt;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [2:0] c, input logic [REG_W-1:0] d,
                      input logic [OPND_W-1:0] o, input logic [ADDR_W-1:0] t);
    in_valid = 1'b1; in_kind = k; in_cond = c; in_dst = d; in_opnd = o; in_tgt = t;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base, n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!out_valid && in_ready, "R1", "reset valid/ready", {out_valid, in_ready}, 1);
    idle(1);

    for (int i = 0; i < NVEC; i++) begin
      logic [10:0] v;
      v = VEC[i];
      wide = v[1];
      base = cap_n;
      send(v[10:8], 3'd0, 5'd1, 16'd10, 32'd0);
      send(v[7:5], v[4:2], 5'd2, 16'd20, 32'd100 + 32'(i));
      idle(5);
      n = cap_n - base;
      if (v[0])
        chk(n == 1 && cap_fused[base] && cap_kind[base] == v[10:8] &&
            cap_cond[base] == v[4:2] && cap_tgt[base] == 32'd100 + 32'(i) &&
            cap_dst[base] == 5'd1, vec_req(i), $sformatf("vector %0d fused count", i), n, 1);
      else
        chk(n == 2 && !cap_fused[base] && !cap_fused[base+1] &&
            cap_kind[base] == v[10:8] && cap_kind[base+1] == v[7:5],
            vec_req(i), $sformatf("vector %0d unfused count", i), n, 2);
    end

    // R8, R10: plain instruction appears the cycle after acceptance
    wide = 1'b0;
    in_valid = 1'b1; in_kind = OTH; in_cond = 3'd6; in_dst = 5'd7; in_opnd = 16'd33; in_tgt = 32'd5;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R8", "plain latency valid", out_valid, 1);
    chk(!out_fused && out_kind == OTH && out_dst == 5'd7 && out_opnd == 16'd33 &&
        out_cond == 3'd6 && out_tgt == 32'd5, "R10", "plain fields dst", out_dst, 7);
    idle(2);

    // R7: lone leader waits one cycle, then goes alone
    in_valid = 1'b1; in_kind = CMP; in_cond = 3'd0; in_dst = 5'd4;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "leader held one cycle", out_valid, 0);
    @(negedge clk);
    chk(out_valid && !out_fused && out_kind == CMP, "R7", "leader emitted alone", out_valid, 1);
    idle(2);

    // R9: flush discards held leader
    in_valid = 1'b1; in_kind = CMP; in_cond = 3'd0;
    @(posedge clk);
    #1 in_valid = 1'b0; flush = 1'b1;
    @(negedge clk);
    chk(!in_ready && !out_valid, "R9", "ready/valid during flush", {in_ready, out_valid}, 0);
    @(posedge clk);
    #1 flush = 1'b0;
    base = cap_n;
    send(BR, 3'd1, 5'd0, 16'd0, 32'd77);
    idle(4);
    chk(cap_n - base == 1 && !cap_fused[base] && cap_kind[base] == BR && cap_tgt[base] == 32'd77,
        "R9", "outputs after flush", cap_n - base, 1);

    // R11: back-pressure with a branch pending
    out_ready = 1'b0;
    base = cap_n;
    fork
      begin
        send(CMP, 3'd0, 5'd3, 16'd1, 32'd0);
        send(BR, 3'd2, 5'd0, 16'd0, 32'd55);
      end
    join_none
    repeat (6) @(negedge clk);
    chk(out_valid && !in_ready && cap_n == base, "R11", "stalled valid held", out_valid, 1);
    @(posedge clk);
    #1 out_ready = 1'b1;
    idle(5);
    chk(cap_n - base == 1 && cap_fused[base] && cap_tgt[base] == 32'd55 &&
        cap_cond[base] == 3'd2 && cap_dst[base] == 5'd3, "R11", "fused after stall", cap_n - base, 1);

    finish_run();
  end
endmodule